// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Back End

This block is the digital half of a nine-stage pipelined analog-to-digital converter. Each stage reports a 2-bit code every clock, and each stage is working on a different sample. The first eight stages produce words that carry one redundant bit. The ninth stage is a plain 2-bit flash. The block deskews the nine codes so that the codes belonging to one sample line up. It then weights and adds them into a 10-bit result, which absorbs any comparator error that the redundancy covers, and saturates the result at full scale.

The result passes through two output registers, which give a fixed latency of seven clocks. On the way out it can be presented as offset binary or as two's complement. An active-low output enable stands in for a tri-state bus: when the bus is released, the data is forced to zero and a drive flag drops. A power-up blanking counter holds a valid flag low until the pipeline has flushed. The stage codes come from analog stages that sit outside this block.

Top module: `pipe_adc_backend`

## Requirements
- R1: Stage k (k = 1..9) drives `stage_codes` bits [2k-1:2k-2]. Odd-numbered stages are captured on the rising clock edge and even-numbered stages on the falling edge. For one sample, stage k's code arrives one half-cycle after stage k-1's code, and stage 1 is captured on rising edge n for sample n.
- R2: The result for a sample is the sum of c_k x 2^(9-k) over k = 1..9, where c_k is stage k's code. Stage 1 weighs 256 and stage 9 weighs 1.
- R3: A sum above 1023 saturates to 1023.
- R4: The result for sample n appears on `dout` right after rising edge n+7. A new result follows on every later clock.
- R5: When `fmt_sel` is 0 the output is offset binary. When it is 1 the output is two's complement, which is the offset-binary word with bit 9 inverted. `fmt_sel` is sampled on the same rising edge that loads the result onto `dout`.
- R6: While `oe_n` is 1, `dout` is all zeros and `dout_oe` is 0, with no clock edge needed. The pipeline keeps running, so the correct data is back as soon as `oe_n` returns to 0.
- R7: `dout_valid` stays 0 through the first 19 rising edges after reset is released. It becomes 1 on the 20th and holds until the next reset.
- R8: A rising edge with `rst_n` at 0 clears the delay lines, the merge register and both output registers. After reset `dout` is zero, and no sample from before the reset ever reaches the output.
- R9: With ideal stages whose comparator thresholds are off by less than a quarter of the reference, the result equals the result of an error-free conversion of the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; both edges are used for stage capture |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_codes | input | 18 | Nine 2-bit stage codes, stage 1 in the lowest bits |
| fmt_sel | input | 1 | 0 selects offset binary, 1 selects two's complement |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 10 | Corrected result, zero while released |
| dout_oe | output | 1 | High when the data bus is driven |
| dout_valid | output | 1 | High once power-up blanking has elapsed |

## Verification
Saturation and format conversion can act on the same result in one cycle. An over-range sum must first be clamped to 1023 and then have its top bit inverted, which gives 511. The bench provokes this with a stream of raw code words that mixes over-range sums with sums landing exactly on 1023 and 1022. It changes `fmt_sel` from sample to sample, so that every result meets its own format on its final edge. Each output is judged against a value computed from the clamp-then-invert rule. If the stages were misaligned, the clamp were placed after the inversion, or the format were taken one edge too early, the result would come out different.

// File: rtl/adc_corr_pkg.sv
// Shared constants for the pipelined ADC correction back end.
// Assumes every stage reports a two-bit code.
package adc_corr_pkg;
    localparam int CODE_W = 2;

    typedef logic [CODE_W-1:0] stg_code_t;

    // Width of the raw weighted sum for a given stage count.
    function automatic int raw_sum_w(input int nstg);
        return nstg + 2;
    endfunction
endpackage

// File: rtl/stage_deskew.sv
// Stage deskew: captures each stage lane on the edge at which its code is
// valid, then delays it on rising edges so that all lanes for one sample
// are presented together. Assumes NSTG is odd, so the last lane is a
// rising-edge lane. Even lane indices (stages 1,3,..) capture on the rising
// edge and odd lane indices capture on the falling edge.
module stage_deskew
    import adc_corr_pkg::*;
#(
    parameter int NSTG = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSTG*CODE_W-1:0]   stage_in,
    output logic [NSTG*CODE_W-1:0]   aligned
);
    localparam int LAST = NSTG - 1;

    for (genvar i = 0; i < NSTG; i++) begin : g_lane
        localparam int DLY = (i % 2 == 0) ? (NSTG - 1 - i) / 2 : (NSTG - i) / 2;
        stg_code_t cap_q;

        if (i % 2 == 0) begin : g_rise
            // Capture a rising-edge lane.
            always_ff @(posedge clk) begin
                if (!rst_n) cap_q <= '0;
                else        cap_q <= stage_in[i*CODE_W +: CODE_W];
            end
        end else begin : g_fall
            // Capture a falling-edge lane.
            always_ff @(negedge clk) begin
                if (!rst_n) cap_q <= '0;
                else        cap_q <= stage_in[i*CODE_W +: CODE_W];
            end
        end

        if (DLY == 0) begin : g_direct
            assign aligned[i*CODE_W +: CODE_W] = cap_q;
        end else begin : g_delay
            stg_code_t dl_q [DLY];
            // Shift the lane along its rising-edge delay line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int j = 0; j < DLY; j++) dl_q[j] <= '0;
                end else begin
                    dl_q[0] <= cap_q;
                    for (int j = 1; j < DLY; j++) dl_q[j] <= dl_q[j-1];
                end
            end
            assign aligned[i*CODE_W +: CODE_W] = dl_q[DLY-1];
        end
    end

    // R1
    last_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> aligned[LAST*CODE_W +: CODE_W] == $past(stage_in[LAST*CODE_W +: CODE_W]));
endmodule

// File: rtl/redund_merge.sv
// Redundancy merge: weights the aligned lanes by powers of two, overlapping
// neighbouring stages by one bit, adds them and saturates at full scale.
// Assumes lane i carries weight 2^(NSTG-1-i). The result is registered.
module redund_merge
    import adc_corr_pkg::*;
#(
    parameter int NSTG = 9,
    localparam int RES_W = NSTG + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSTG*CODE_W-1:0]   aligned,
    output logic [RES_W-1:0]         corr_q
);
    localparam int SUMW = raw_sum_w(NSTG);
    localparam logic [SUMW-1:0] FULL = SUMW'((1 << RES_W) - 1);

    logic [SUMW-1:0] raw;

    // Form the weighted sum of all lanes.
    always_comb begin
        raw = '0;
        for (int i = 0; i < NSTG; i++) begin
            raw = raw + (SUMW'(aligned[i*CODE_W +: CODE_W]) << (NSTG - 1 - i));
        end
    end

    // Register the saturated result.
    always_ff @(posedge clk) begin
        if (!rst_n)          corr_q <= '0;
        else if (raw > FULL) corr_q <= '1;
        else                 corr_q <= raw[RES_W-1:0];
    end

    // R2
    corr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(raw) <= FULL) |-> corr_q == $past(raw[RES_W-1:0]));

    // R3
    clamp_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(raw) > FULL) |-> corr_q == FULL[RES_W-1:0]);
endmodule

// File: rtl/out_format.sv
// Output stage: two result registers, with the format choice applied on the
// second one, followed by a release gate that zeroes the bus while it is
// not driven. Assumes the format input is synchronous to the clock.
module out_format #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] corr,
    input  logic             fmt_sel,
    input  logic             oe_n,
    output logic [RES_W-1:0] dout,
    output logic             dout_oe
);
    localparam int MSB = RES_W - 1;

    logic [RES_W-1:0] buf1_q;
    logic [RES_W-1:0] buf2_q;

    // First buffer: hold the merged result.
    always_ff @(posedge clk) begin
        if (!rst_n) buf1_q <= '0;
        else        buf1_q <= corr;
    end

    // Second buffer: apply the number format.
    always_ff @(posedge clk) begin
        if (!rst_n) buf2_q <= '0;
        else        buf2_q <= {buf1_q[MSB] ^ fmt_sel, buf1_q[MSB-1:0]};
    end

    // Gate the bus while it is released.
    always_comb begin
        dout_oe = ~oe_n;
        dout    = oe_n ? '0 : buf2_q;
    end

    // R5
    fmt_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> buf2_q[MSB] == ($past(buf1_q[MSB]) ^ $past(fmt_sel)));

    // R4
    buf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> buf2_q[MSB-1:0] == $past(buf1_q[MSB-1:0]));
endmodule

// File: rtl/blank_timer.sv
// Power-up blanking: counts rising edges after reset and raises the valid
// flag once BLANK_CYC edges have passed. Assumes BLANK_CYC is at least one.
module blank_timer #(
    parameter int BLANK_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic valid
);
    localparam int CNTW = $clog2(BLANK_CYC + 1);
    localparam logic [CNTW-1:0] CNT_END = CNTW'(BLANK_CYC);

    logic [CNTW-1:0] cnt_q;

    // Count up to the end value and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
    end

    assign valid = (cnt_q == CNT_END);

    // R7
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);
endmodule

// File: rtl/pipe_adc_backend.sv
// Top of the pipelined ADC digital back end. Chain: lane deskew, redundancy
// merge, double output buffer with format select and bus release, plus the
// power-up blanking timer. The latency is seven rising edges from the
// stage-1 capture to the output.
module pipe_adc_backend
    import adc_corr_pkg::*;
#(
    parameter int NSTG      = 9,
    parameter int BLANK_CYC = 20,
    localparam int RES_W    = NSTG + 1,
    localparam int IN_W     = NSTG * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  stage_codes,
    input  logic             fmt_sel,
    input  logic             oe_n,
    output logic [RES_W-1:0] dout,
    output logic             dout_oe,
    output logic             dout_valid
);
    logic [IN_W-1:0]  aligned;
    logic [RES_W-1:0] corr;

    stage_deskew #(.NSTG(NSTG)) u_deskew (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_in (stage_codes),
        .aligned  (aligned)
    );

    redund_merge #(.NSTG(NSTG)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .aligned (aligned),
        .corr_q  (corr)
    );

    out_format #(.RES_W(RES_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .corr    (corr),
        .fmt_sel (fmt_sel),
        .oe_n    (oe_n),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (dout_valid)
    );
endmodule

// File: tb/pipe_adc_backend_bench.sv
`timescale 1ns/100ps
module pipe_adc_backend_bench;
    localparam int VR = 131072;       // reference in 1/256-LSB units
    localparam int WD_CYCLES = 20000;
    localparam int NV = 16;
    // analog code, sub-LSB fraction, expected offset-binary result
    localparam int VEC [NV][3] = '{
        '{0, 0, 0},       '{1, 255, 1},     '{2, 128, 2},     '{127, 7, 127},
        '{256, 0, 256},   '{383, 200, 383}, '{511, 255, 511}, '{512, 0, 512},
        '{513, 1, 513},   '{640, 64, 640},  '{777, 33, 777},  '{900, 250, 900},
        '{1000, 99, 1000},'{1021, 128, 1021},'{1022, 255, 1022},'{1023, 255, 1023}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] stage_codes = '0;
    logic        fmt_sel = 1'b0;
    logic        oe_n = 1'b0;
    logic [9:0]  dout;
    logic        dout_oe;
    logic        dout_valid;

    logic [17:0] cmem [0:63];
    int          expv [0:63];
    logic        fmtv [0:63];
    int          n_total = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    pipe_adc_backend u_pipe_adc_backend (
        .clk(clk), .rst_n(rst_n), .stage_codes(stage_codes), .fmt_sel(fmt_sel),
        .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe), .dout_valid(dout_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Ideal nine-stage converter with optional comparator offsets.
    function automatic logic [17:0] stage_model(input int x, input int f, input int ea, input int salt);
        int r, d, e, c9;
        logic [17:0] w;
        r = (x - 512) * 256 + f;
        for (int k = 0; k < 8; k++) begin
            e = (ea == 0) ? 0 : ((x * 37 + k * 101 + salt * 13) % (2 * ea + 1)) - ea;
            if (r >= VR / 4 + e)       d = 1;
            else if (r >= -VR / 4 - e) d = 0;
            else                       d = -1;
            w[2*k +: 2] = 2'(d + 1);
            r = 2 * r - d * VR;
        end
        c9 = (r + VR) / (VR / 2);
        if (c9 > 3) c9 = 3;
        if (c9 < 0) c9 = 0;
        w[17:16] = 2'(c9);
        return w;
    endfunction

    // Drive one edge class of lanes for cycle m (odd: falling edge m, even: rising edge m+1).
    task automatic drive_lanes(input bit odd, input int m, input int nsamp);
        for (int i = 0; i < 9; i++) begin
            if ((i % 2 == 1) == odd) begin
                int idx;
                idx = odd ? m - (i - 1) / 2 : m + 1 - i / 2;
                stage_codes[2*i +: 2] = (idx >= 0 && idx < nsamp) ? cmem[idx][2*i +: 2] : 2'b00;
            end
        end
    endtask

    // Stream nsamp samples with staggered lanes and check each at latency 7.
    task automatic run_stream(input int nsamp, input int oe_cycle, input string tag);
        drive_lanes(1'b0, -1, nsamp);
        drive_lanes(1'b1, -1, nsamp);
        for (int m = 0; m <= nsamp + 6; m++) begin
            @(posedge clk); #2;
            if (m >= 7) chk(int'(dout) == expv[m-7] && dout_oe, tag, int'(dout), expv[m-7]);
            if (m - 6 >= 0 && m - 6 < nsamp) fmt_sel = fmtv[m-6];
            drive_lanes(1'b1, m, nsamp);
            if (m == oe_cycle) begin
                oe_n = 1'b1; #1;
                chk(dout == 10'd0 && !dout_oe, "R6 released bus", int'(dout), 0);
                oe_n = 1'b0; #0.5;
                chk(int'(dout) == expv[m-7] && dout_oe, "R6 data back after release", int'(dout), expv[m-7]);
                #2.5;
            end else begin
                #4;
            end
            drive_lanes(1'b0, m, nsamp);
        end
    endtask

    task automatic fill_vec(input int ea, input int salt, input bit fmt);
        for (int n = 0; n < NV; n++) begin
            cmem[n] = stage_model(VEC[n][0], VEC[n][1], ea, salt);
            fmtv[n] = fmt;
            expv[n] = VEC[n][2] ^ (fmt ? 512 : 0);
        end
    endtask

    task automatic set_raw(input int n, input logic [17:0] w, input bit fmt, input int ob);
        cmem[n] = w;
        fmtv[n] = fmt;
        expv[n] = ob ^ (fmt ? 512 : 0);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL R4 watchdog expired: cycles %0d expected below %0d", WD_CYCLES, WD_CYCLES);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin : main
        // Reset state (R8, R7)
        repeat (3) @(posedge clk);
        #2;
        chk(dout == 10'd0, "R8 dout zero in reset", int'(dout), 0);
        chk(!dout_valid, "R7 valid low in reset", int'(dout_valid), 0);
        #4 rst_n = 1'b1;

        // Blanking window (R7)
        for (int e = 1; e <= 20; e++) begin
            @(posedge clk); #2;
            if (e == 19) chk(!dout_valid, "R7 valid low at edge 19", int'(dout_valid), 0);
            if (e == 20) chk(dout_valid, "R7 valid high at edge 20", int'(dout_valid), 1);
        end
        #4;

        // Vector table: ideal stages, then with comparator offsets, then two's complement
        fill_vec(0, 0, 1'b0);
        run_stream(NV, -1, "R1 R2 R4 ideal stages");
        fill_vec(30000, 1, 1'b0);
        run_stream(NV, -1, "R9 R2 offsets tolerated");
        fill_vec(30000, 2, 1'b1);
        run_stream(NV, -1, "R5 R9 two's complement");

        // Saturation meeting format inversion (R3, R5)
        set_raw(0, 18'h3FFFF, 1'b0, 1023);
        set_raw(1, 18'h3FFFF, 1'b1, 1023);
        set_raw(2, 18'h0000B, 1'b1, 1023);
        set_raw(3, 18'h15557, 1'b0, 1023);
        set_raw(4, 18'h15557, 1'b1, 1023);
        set_raw(5, 18'h05557, 1'b0, 1022);
        set_raw(6, 18'h00000, 1'b1, 0);
        set_raw(7, 18'h00000, 1'b0, 0);
        run_stream(8, -1, "R3 R5 clamp with format");

        // Bus release mid-stream (R6)
        for (int n = 0; n < 20; n++) begin
            cmem[n] = stage_model(700, 100, 30000, 3);
            fmtv[n] = 1'b0;
            expv[n] = 700;
        end
        run_stream(20, 15, "R6 stream around release");

        // Reset during a full pipeline (R8, R7)
        stage_codes = 18'h3FFFF;
        repeat (8) @(posedge clk);
        #6;
        rst_n = 1'b0;
        stage_codes = '0;
        repeat (2) @(posedge clk);
        #6;
        rst_n = 1'b1;
        for (int c = 1; c <= 9; c++) begin
            @(posedge clk); #2;
            chk(dout == 10'd0, "R8 no stale sample after reset", int'(dout), 0);
            if (c == 1) chk(!dout_valid, "R7 blanking restarts", int'(dout_valid), 0);
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule